// File: doc/BRIEF.md
# FIFO Burst Transfer Sequencer

This block collects samples from a parallel port into a 512-entry first-in first-out store, from which a host drains them in back-to-back burst reads. Each sample strobe carries one data word. When the burst mode is enabled, a down-counter limits how many samples one transfer may capture. Once the counter reaches its terminal count, capture stops and a completion flag rises.

The counter can be started in two ways. In single-shot mode, writing a count to the load register starts a run at once. In continuous mode, the load register only holds the count. Each write to the write-only arm strobe then reloads the counter from the stored count and starts a fresh run of the same length, so a long acquisition can be cut into equal bursts.

Status outputs report empty, full, half-full and completion. The block raises a service request when the host has a burst worth of data, or a finished remainder, to collect. Optional overrun and underrun detection catches samples that arrive with no room and reads that find nothing. That detection matters once a transfer is longer than the store.

Top module: `fbs_burst_seq`

## Requirements
- R1: Accepted samples leave in arrival order; `rd_data` shows the oldest stored word, and a read strobe while not empty removes it. The store holds 512 words.
- R2: `empty` is 1 with zero words and `full` is 1 with 512 words; a sample offered while full is dropped and the stored contents are unchanged.
- R3: With `rep_en`=0 every sample strobe is stored (room permitting), no count limit applies, and `done` reads 0.
- R4: With `rep_en`=1 and `cont_mode`=0, a load write of N starts a run that stores exactly the next N strobed samples and drops later ones; N=0 stores none.
- R5: `done` rises in the cycle after the sample that brings the count to zero, stays high until the next run start, and is cleared by that start.
- R6: With `rep_en`=1 and `cont_mode`=1, a load write only stores the count (no samples are taken); each `arm_we` pulse reloads the stored count and starts a run of that length.
- R7: `half` is 1 exactly when `rep_en`=1 and at least 256 words are stored.
- R8: `req` is 1 exactly when `rep_en`=1 and either `half` is 1 or (`done` is 1 and the store is not empty).
- R9: With `err_en`=1, a sample strobe that the count limit would admit but that meets a full store sets `overrun`, which stays set while `err_en` remains 1.
- R10: With `err_en`=1, a read strobe while empty sets `underrun`, which stays set while `err_en` remains 1.
- R11: With `err_en`=0, `overrun` and `underrun` read 0 from the next cycle on, and neither can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe from the port |
| smp_data | input | 16 | Sample word |
| rd_stb | input | 1 | Host read strobe |
| rep_en | input | 1 | Burst mode enable (count-limited capture) |
| cont_mode | input | 1 | 1: arm strobe starts runs; 0: load write starts a run |
| err_en | input | 1 | Enables overrun and underrun detection |
| cnt_ld_we | input | 1 | Load register write strobe |
| cnt_ld_val | input | 16 | Sample count for a run |
| arm_we | input | 1 | Write-only arm strobe |
| rd_data | output | 16 | Oldest stored word |
| empty | output | 1 | Store empty |
| full | output | 1 | Store full |
| half | output | 1 | Half-full level flag |
| done | output | 1 | Run reached terminal count |
| overrun | output | 1 | Sample arrived with store full |
| underrun | output | 1 | Read with store empty |
| req | output | 1 | Service request to the host |

## Verification
The bench targets the sample at the terminal count: a counter that stops one sample early or late would store two or four words where three are expected. It also checks that a zero count stores nothing, and that a design which wraps its count would instead store a long run. A continuous-mode design that starts on the load write, or that fails to reload on a second arm, would store samples while none are expected. The bench fills the store exactly to 256 and 512 words. There, an off-by-one level compare misplaces `half`, and a store that overwrites when full corrupts the scoreboard order. It also checks that the error flags stay set and that they clear and lock out when detection is disabled.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
   // status bundle shared between the sub-blocks and the top
   typedef struct packed {
      logic empty;
      logic full;
      logic half;
      logic done;
      logic overrun;
      logic underrun;
   } fbs_status_t;

   // run start source selected by the mode bit
   typedef enum logic {
      START_ON_LOAD = 1'b0,
      START_ON_ARM  = 1'b1
   } fbs_start_e;
endpackage

// File: rtl/fbs_fifo.sv
module fbs_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH),
   localparam int CNTW = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic [CNTW-1:0] count,
   output logic            full,
   output logic            empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign full  = (count == CNTW'(DEPTH));
   assign empty = (count == '0);

   a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r1_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   a_r1_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == CNTW'($past(count) + 1'b1)));
endmodule

// File: rtl/fbs_sample_ctr.sv
module fbs_sample_ctr #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_sel,
   input  logic          ld_we,
   input  logic [CW-1:0] ld_val,
   input  logic          arm_we,
   input  logic          take,
   output logic          open,
   output logic          done_q
);
   import fbs_pkg::*;

   logic [CW-1:0] ld_q;
   logic [CW-1:0] remaining;
   logic          restart;
   logic [CW-1:0] restart_val;

   always_comb begin
      restart     = 1'b0;
      restart_val = ld_q;
      if (fbs_start_e'(start_sel) == START_ON_LOAD) begin
         restart     = ld_we;
         restart_val = ld_val;
      end else begin
         restart     = arm_we;
         restart_val = ld_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_q      <= '0;
         remaining <= '0;
         done_q    <= 1'b0;
      end else begin
         if (ld_we) ld_q <= ld_val;
         if (restart) begin
            remaining <= restart_val;
            done_q    <= 1'b0;
         end else if (take && remaining != '0) begin
            remaining <= remaining - 1'b1;
            if (remaining == CW'(1)) done_q <= 1'b1;
         end
      end
   end

   assign open = (remaining != '0);

   a_r4_take_only_while_open: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> remaining != '0);
   a_r5_done_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !restart && remaining == CW'(1)) |=> (done_q && remaining == '0));
   a_r5_done_cleared_by_start: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !done_q);
endmodule

// File: rtl/fbs_err_flags.sv
module fbs_err_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic err_en,
   input  logic ovr_evt,
   input  logic udr_evt,
   output logic overrun,
   output logic underrun
);
   always_ff @(posedge clk) begin
      if (!rst_n || !err_en) begin
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         overrun  <= overrun  | ovr_evt;
         underrun <= underrun | udr_evt;
      end
   end

   a_r11_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !err_en |=> (!overrun && !underrun));
   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && err_en) |=> overrun);
   a_r10_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (err_en && udr_evt) |=> underrun);
endmodule

// File: rtl/fbs_burst_seq.sv
module fbs_burst_seq #(
   parameter int DW         = 16,
   parameter int DEPTH      = 512,
   parameter int CW         = 16,
   parameter bit ERR_DETECT = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int CNTW      = AW + 1,
   localparam int HALF_MARK = DEPTH / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_stb,
   input  logic [DW-1:0] smp_data,
   input  logic          rd_stb,
   input  logic          rep_en,
   input  logic          cont_mode,
   input  logic          err_en,
   input  logic          cnt_ld_we,
   input  logic [CW-1:0] cnt_ld_val,
   input  logic          arm_we,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic          full,
   output logic          half,
   output logic          done,
   output logic          overrun,
   output logic          underrun,
   output logic          req
);
   import fbs_pkg::*;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("fbs_burst_seq: DEPTH must be a power of two of at least 4");
   end
   if (DW < 1 || CW < 1) begin : g_bad_width
      $error("fbs_burst_seq: DW and CW must be positive");
   end

   fbs_status_t    st;
   logic [CNTW-1:0] level;
   logic            ctr_open, done_q, gate, push, pop, take;

   assign gate = rep_en ? ctr_open : 1'b1;
   assign push = smp_stb && gate && !st.full;
   assign pop  = rd_stb && !st.empty;
   assign take = push && rep_en;

   fbs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(smp_data),
      .rdata(rd_data), .count(level), .full(st.full), .empty(st.empty)
   );

   fbs_sample_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .start_sel(cont_mode), .ld_we(cnt_ld_we),
      .ld_val(cnt_ld_val), .arm_we(arm_we), .take(take),
      .open(ctr_open), .done_q(done_q)
   );

   if (ERR_DETECT) begin : g_err
      fbs_err_flags u_err (
         .clk(clk), .rst_n(rst_n), .err_en(err_en),
         .ovr_evt(smp_stb && gate && st.full),
         .udr_evt(rd_stb && st.empty),
         .overrun(st.overrun), .underrun(st.underrun)
      );
   end else begin : g_no_err
      assign st.overrun  = 1'b0;
      assign st.underrun = 1'b0;
   end

   assign st.half = rep_en && (level >= CNTW'(HALF_MARK));
   assign st.done = rep_en && done_q;

   assign empty    = st.empty;
   assign full     = st.full;
   assign half     = st.half;
   assign done     = st.done;
   assign overrun  = st.overrun;
   assign underrun = st.underrun;
   assign req      = rep_en && (st.half || (st.done && !st.empty));

   a_r8_req_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> !empty);
   a_r3_free_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!rep_en && smp_stb && !full && !rd_stb) |=> !empty);
   a_r7_half_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      half |-> (rep_en && !empty));
endmodule

// File: tb/tb_fbs_burst_seq.sv
module tb_fbs_burst_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0, rd_stb = 1'b0, rep_en = 1'b0, cont_mode = 1'b0;
   logic        err_en = 1'b0, cnt_ld_we = 1'b0, arm_we = 1'b0;
   logic [15:0] smp_data = '0, cnt_ld_val = '0;
   logic [15:0] rd_data;
   logic        empty, full, half, done, overrun, underrun, req;

   int checks = 0;
   int fails  = 0;
   logic [15:0] sb[$];

   always #2.5 clk = ~clk;

   fbs_burst_seq dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
      .rd_stb(rd_stb), .rep_en(rep_en), .cont_mode(cont_mode), .err_en(err_en),
      .cnt_ld_we(cnt_ld_we), .cnt_ld_val(cnt_ld_val), .arm_we(arm_we),
      .rd_data(rd_data), .empty(empty), .full(full), .half(half), .done(done),
      .overrun(overrun), .underrun(underrun), .req(req)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compares each popped word with the scoreboard (R1)
   always @(negedge clk) begin
      if (rst_n && rd_stb && !empty) begin
         if (sb.size() == 0) check("R1 unexpected word", int'(rd_data), -1);
         else check("R1 order", int'(rd_data), int'(sb.pop_front()));
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic push(input logic [15:0] d, input bit exp_acc);
      smp_stb = 1'b1; smp_data = d;
      if (exp_acc) sb.push_back(d);
      tick();
      smp_stb = 1'b0;
   endtask

   task automatic pull(input int n);
      for (int i = 0; i < n; i++) begin
         rd_stb = 1'b1; tick(); rd_stb = 1'b0;
      end
   endtask

   task automatic load(input int n);
      cnt_ld_we = 1'b1; cnt_ld_val = 16'(n); tick(); cnt_ld_we = 1'b0;
   endtask

   task automatic arm();
      arm_we = 1'b1; tick(); arm_we = 1'b0;
   endtask

   initial begin
      #(5.0 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1; tick();
      // reset state
      check("R2 reset empty", empty, 1);
      check("R2 reset full", full, 0);
      check("R5 reset done", done, 0);
      check("R8 reset req", req, 0);
      check("R9 reset overrun", overrun, 0);

      // R3: free capture
      for (int i = 0; i < 5; i++) push(16'h1000 + 16'(i), 1'b1);
      check("R3 done low", done, 0);
      check("R3 nonempty", empty, 0);
      pull(5);
      check("R1 drained", empty, 1);
      check("R1 scoreboard", sb.size(), 0);

      // R4/R5: single-shot run of 3
      rep_en = 1'b1; cont_mode = 1'b0;
      load(3);
      push(16'h2000, 1); push(16'h2001, 1);
      check("R5 done before terminal", done, 0);
      push(16'h2002, 1);
      check("R5 done at terminal", done, 1);
      push(16'h2003, 0); push(16'h2004, 0); push(16'h2005, 0);
      check("R5 done held", done, 1);
      check("R8 req remainder", req, 1);
      pull(3);
      check("R4 exactly three", empty, 1);
      check("R8 req cleared", req, 0);

      // R6: continuous mode
      cont_mode = 1'b1;
      load(4);
      push(16'h3000, 0); push(16'h3001, 0);
      check("R6 load does not start", empty, 1);
      arm();
      check("R6 arm clears done", done, 0);
      for (int i = 0; i < 5; i++) push(16'h3100 + 16'(i), i < 4);
      check("R6 first run done", done, 1);
      arm();
      check("R6 rearm clears done", done, 0);
      for (int i = 0; i < 5; i++) push(16'h3200 + 16'(i), i < 4);
      check("R6 second run done", done, 1);
      pull(8);
      check("R6 eight stored", empty, 1);

      // R4: zero count stores nothing
      cont_mode = 1'b0;
      load(0);
      push(16'h4000, 0); push(16'h4001, 0);
      check("R4 zero count empty", empty, 1);
      check("R4 zero count done", done, 0);

      // R7/R8: half mark
      load(300);
      for (int i = 0; i < 255; i++) push(16'(i), 1'b1);
      check("R7 below half", half, 0);
      check("R8 req below half", req, 0);
      push(16'h0aff, 1'b1);
      check("R7 at half", half, 1);
      check("R8 req at half", req, 1);
      rep_en = 1'b0; #1;
      check("R7 half gated off", half, 0);
      check("R8 req gated off", req, 0);
      check("R3 done gated off", done, 0);
      pull(256);
      check("R1 half drained", sb.size(), 0);

      // R2/R9: full and overrun
      err_en = 1'b1;
      for (int i = 0; i < 512; i++) push(16'h5000 + 16'(i), 1'b1);
      check("R2 full", full, 1);
      check("R9 no overrun yet", overrun, 0);
      push(16'hdead, 1'b0);
      check("R9 overrun set", overrun, 1);
      check("R2 still full", full, 1);
      pull(1);
      check("R9 overrun sticky", overrun, 1);
      err_en = 1'b0; tick();
      check("R11 overrun cleared", overrun, 0);
      pull(511);
      check("R2 no overwrite", sb.size(), 0);

      // R10/R11: underrun
      pull(1);
      check("R11 underrun locked out", underrun, 0);
      err_en = 1'b1;
      pull(1);
      check("R10 underrun set", underrun, 1);
      tick();
      check("R10 underrun sticky", underrun, 1);
      err_en = 1'b0; tick();
      check("R11 underrun cleared", underrun, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule